// File: doc/BRIEF.md
# Descriptor Ring Post Tracker

This block keeps the pointer state of a set of descriptor rings that feed an egress DMA descriptor fetcher. Software announces new work with one store per post. The store names the ring in its address and carries the ring's tail before the post, together with the number of descriptors added. The tracker works out the new tail modulo the ring size and keeps an outstanding-descriptor count for each ring. A ring with outstanding work, or one that was woken, raises its pending line so that the fetcher serves it.

The fetcher is represented by simple strobes. A fetch strobe consumes the descriptor at a ring's head. A completion strobe reports one fully processed descriptor. A flush control sets or clears a per-ring flush bit. A load to a ring returns its head pointer, its rolling completion count and its generation bit. The generation bit toggles each time the head wraps, so valid descriptors are the ones that carry its inverse. The ring size is a power-of-two parameter, and all pointer arithmetic is therefore a truncating add.

Top module: `dring_tracker`

## Requirements
- R1: After reset every ring reads head 0, completion count 0 and generation 0, no ring is pending, and `mmio_rvalid` is 0.
- R2: An access is taken only when address bits [7:5] equal 5 and the ring field in bits [4:0] is below NUM_RINGS. A post whose index has any bit set at or above the ring size is also dropped. A dropped access changes no state and produces no read response.
- R3: A post carries its index in write bits [15:0] and its count in bits [31:16]. For a count from 1 to DEPTH, the new tail is (index + count) mod DEPTH. The outstanding amount becomes (new tail − head) mod DEPTH, or DEPTH when that difference is 0. The ring is pending while the outstanding amount is nonzero.
- R4: A post with count 0 leaves tail and outstanding amount unchanged and wakes the ring, so that it is pending. The next fetch then advances the head by one even with nothing outstanding, and any fetch clears the wake.
- R5: A fetch strobe for a pending ring advances its head by one modulo DEPTH and lowers its outstanding amount by one. A fetch strobe for a ring that is not pending has no effect.
- R6: The generation bit of a ring toggles exactly when its head steps from DEPTH−1 to 0.
- R7: A load is answered in the cycle after it is accepted, with `mmio_rvalid` high for that single cycle. The data holds the generation bit in bit 32, the completion count in bits [31:16] and the zero-extended head in bits [15:0].
- R8: Each completion strobe adds one to the ring's 16-bit completion count, wrapping modulo 2^16.
- R9: Writing the flush bit from 1 to 0 clears the completion count, and this clear overrides a completion in the same cycle. Setting the bit, or writing a value equal to the current one, leaves the count unchanged.
- R10: Posts, fetches, completions and flushes for one ring leave every other ring's state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mmio_wr | input | 1 | Post store strobe |
| mmio_rd | input | 1 | Status load strobe |
| mmio_addr | input | 8 | Region select [7:5], ring select [4:0] |
| mmio_wdata | input | 32 | Count [31:16], old tail index [15:0] |
| mmio_rvalid | output | 1 | Load response valid |
| mmio_rdata | output | 33 | Generation [32], completion count [31:16], head [15:0] |
| fetch_valid | input | 1 | Fetcher consumes one descriptor |
| fetch_ring | input | 5 | Ring addressed by the fetch strobe |
| complete_valid | input | 1 | One descriptor fully processed |
| complete_ring | input | 5 | Ring addressed by the completion strobe |
| flush_wr | input | 1 | Write the flush bit |
| flush_ring | input | 5 | Ring addressed by the flush write |
| flush_val | input | 1 | New flush bit value |
| ring_pending | output | NUM_RINGS | Per-ring work available |

## Verification
Post, fetch, completion and flush strobes update registered state at the clock edge where they are sampled. The pending lines are decoded from that state, so they show the new value in the same cycle after that edge. A load is captured at its edge and shows the state from before that edge. The bench drives every strobe just after a rising edge, holds it for exactly one edge and samples one time unit after that edge, which is where both kinds of result have settled. An index-by-count sweep on an eight-entry ring drains each post through the pending line and compares the number of fetches, the head and the generation bit with values computed arithmetically.

// File: rtl/dring_pkg.sv
package dring_pkg;

    localparam int IDX_W    = 16;
    localparam int CNT_W    = 16;
    localparam int RING_W   = 5;
    localparam int REGION_W = 3;
    localparam int ADDR_W   = REGION_W + RING_W;
    localparam int WDATA_W  = CNT_W + IDX_W;
    localparam int RDATA_W  = 1 + CNT_W + IDX_W;

    localparam logic [REGION_W-1:0] POST_REGION = 3'd5;

    typedef struct packed {
        logic [REGION_W-1:0] region;
        logic [RING_W-1:0]   ring;
    } ring_addr_t;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [IDX_W-1:0] idx;
    } post_word_t;

    typedef struct packed {
        logic             gen;
        logic [CNT_W-1:0] done;
        logic [IDX_W-1:0] head;
    } status_word_t;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_POST = 2'd1,
        OP_READ = 2'd2
    } ring_op_e;

    typedef struct packed {
        ring_op_e          op;
        logic [RING_W-1:0] ring;
        post_word_t        word;
    } ring_req_t;

    function automatic logic ring_in_range(logic [RING_W-1:0] ring, int unsigned n);
        return 32'(ring) < n;
    endfunction

    function automatic logic idx_in_range(logic [IDX_W-1:0] idx, int unsigned ptr_w);
        return (idx >> ptr_w) == '0;
    endfunction

endpackage

// File: rtl/dring_decode.sv
module dring_decode
    import dring_pkg::*;
#(
    parameter int NUM_RINGS = 4,
    parameter int PTR_W     = 4
) (
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [WDATA_W-1:0] wdata,
    output ring_req_t          req
);

    ring_addr_t a;
    post_word_t w;
    logic       hit;

    always_comb begin
        a        = addr;
        w        = wdata;
        hit      = (a.region == POST_REGION) && ring_in_range(a.ring, NUM_RINGS);
        req.op   = OP_NONE;
        req.ring = a.ring;
        req.word = w;
        if (hit && wr_en) begin
            if (idx_in_range(w.idx, PTR_W)) begin
                req.op = OP_POST;
            end
        end else if (hit && rd_en) begin
            req.op = OP_READ;
        end
    end

endmodule

// File: rtl/dring_slot.sv
module dring_slot
    import dring_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             post_en,
    input  logic [PTR_W-1:0] post_idx,
    input  logic [CNT_W-1:0] post_cnt,
    input  logic             fetch_en,
    input  logic             complete_en,
    input  logic             flush_wr,
    input  logic             flush_val,
    output logic [PTR_W-1:0] head,
    output logic             gen,
    output logic [CNT_W-1:0] done,
    output logic             pending
);

    localparam logic [PTR_W:0]   FULL = (PTR_W+1)'(DEPTH);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [PTR_W-1:0] head_q, tail_q, head_nxt, sum_tail, gap;
    logic [PTR_W:0]   avail_q;
    logic             wake_q, gen_q, flush_q;
    logic [CNT_W-1:0] done_q;
    logic             wake_post, work_post;

    assign wake_post = post_en && (post_cnt == '0);
    assign work_post = post_en && (post_cnt != '0);
    assign head_nxt  = fetch_en ? PTR_W'(head_q + 1'b1) : head_q;
    assign sum_tail  = PTR_W'(post_idx + post_cnt[PTR_W-1:0]);
    assign gap       = PTR_W'(sum_tail - head_nxt);

    assign pending = (avail_q != '0) || wake_q;
    assign head    = head_q;
    assign gen     = gen_q;
    assign done    = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q  <= '0;
            tail_q  <= '0;
            avail_q <= '0;
            wake_q  <= 1'b0;
            gen_q   <= 1'b0;
            flush_q <= 1'b0;
            done_q  <= '0;
        end else begin
            if (fetch_en) begin
                head_q <= head_nxt;
                if (head_q == LAST) begin
                    gen_q <= ~gen_q;
                end
            end

            if (work_post) begin
                tail_q  <= sum_tail;
                avail_q <= (gap == '0) ? FULL : {1'b0, gap};
            end else if (fetch_en) begin
                if (avail_q != '0) begin
                    avail_q <= avail_q - 1'b1;
                end else begin
                    tail_q <= head_nxt;
                end
            end

            if (wake_post) begin
                wake_q <= 1'b1;
            end else if (fetch_en) begin
                wake_q <= 1'b0;
            end

            if (flush_wr) begin
                flush_q <= flush_val;
            end

            if (flush_wr && flush_q && !flush_val) begin
                done_q <= '0;
            end else if (complete_en) begin
                done_q <= done_q + 1'b1;
            end
        end
    end

    // R3: stored tail and outstanding amount stay consistent with the head
    p_tail_gap_r3: assert property (@(posedge clk) disable iff (rst)
        avail_q[PTR_W-1:0] == PTR_W'(tail_q - head_q));

    p_avail_cap_r3: assert property (@(posedge clk) disable iff (rst)
        avail_q <= FULL);

    // R4: a zero-count post always leaves the ring pending
    p_wake_r4: assert property (@(posedge clk) disable iff (rst)
        wake_post |=> pending);

    // R5: the head only ever moves forward by one entry
    p_head_step_r5: assert property (@(posedge clk) disable iff (rst)
        (head_q != $past(head_q)) |-> (head_q == PTR_W'($past(head_q) + 1'b1)));

    // R6: generation flips only on the wrap from the last entry to entry 0
    p_gen_wrap_r6: assert property (@(posedge clk) disable iff (rst)
        (gen_q != $past(gen_q)) |-> ($past(head_q) == LAST && head_q == '0));

    // R9: a falling flush bit leaves a cleared completion count
    p_flush_clear_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(flush_q) |-> (done_q == '0));

endmodule

// File: rtl/dring_tracker.sv
module dring_tracker
    import dring_pkg::*;
#(
    parameter  int NUM_RINGS = 4,
    parameter  int DEPTH     = 16,
    localparam int PTR_W     = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 mmio_wr,
    input  logic                 mmio_rd,
    input  logic [ADDR_W-1:0]    mmio_addr,
    input  logic [WDATA_W-1:0]   mmio_wdata,
    output logic                 mmio_rvalid,
    output logic [RDATA_W-1:0]   mmio_rdata,
    input  logic                 fetch_valid,
    input  logic [RING_W-1:0]    fetch_ring,
    input  logic                 complete_valid,
    input  logic [RING_W-1:0]    complete_ring,
    input  logic                 flush_wr,
    input  logic [RING_W-1:0]    flush_ring,
    input  logic                 flush_val,
    output logic [NUM_RINGS-1:0] ring_pending
);

    ring_req_t        req;
    logic [PTR_W-1:0] head_a [NUM_RINGS];
    logic             gen_a  [NUM_RINGS];
    logic [CNT_W-1:0] done_a [NUM_RINGS];
    status_word_t     rd_sel;

    dring_decode #(
        .NUM_RINGS (NUM_RINGS),
        .PTR_W     (PTR_W)
    ) u_decode (
        .wr_en (mmio_wr),
        .rd_en (mmio_rd),
        .addr  (mmio_addr),
        .wdata (mmio_wdata),
        .req   (req)
    );

    for (genvar i = 0; i < NUM_RINGS; i++) begin : g_ring
        logic sel_post, sel_fetch, sel_done, sel_flush;

        assign sel_post  = (req.op == OP_POST) && (req.ring == RING_W'(i));
        assign sel_fetch = fetch_valid && (fetch_ring == RING_W'(i)) && ring_pending[i];
        assign sel_done  = complete_valid && (complete_ring == RING_W'(i));
        assign sel_flush = flush_wr && (flush_ring == RING_W'(i));

        dring_slot #(
            .DEPTH (DEPTH)
        ) u_slot (
            .clk         (clk),
            .rst         (rst),
            .post_en     (sel_post),
            .post_idx    (req.word.idx[PTR_W-1:0]),
            .post_cnt    (req.word.cnt),
            .fetch_en    (sel_fetch),
            .complete_en (sel_done),
            .flush_wr    (sel_flush),
            .flush_val   (flush_val),
            .head        (head_a[i]),
            .gen         (gen_a[i]),
            .done        (done_a[i]),
            .pending     (ring_pending[i])
        );

        // R5: a fetch aimed at an idle ring leaves its head alone
        p_idle_fetch_r5: assert property (@(posedge clk) disable iff (rst)
            (fetch_valid && fetch_ring == RING_W'(i) && !ring_pending[i]) |=> $stable(head_a[i]));
    end

    always_comb begin
        rd_sel = '0;
        for (int r = 0; r < NUM_RINGS; r++) begin
            if (req.ring == RING_W'(r)) begin
                rd_sel.gen  = gen_a[r];
                rd_sel.done = done_a[r];
                rd_sel.head = IDX_W'(head_a[r]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mmio_rvalid <= 1'b0;
            mmio_rdata  <= '0;
        end else begin
            mmio_rvalid <= (req.op == OP_READ);
            if (req.op == OP_READ) begin
                mmio_rdata <= rd_sel;
            end
        end
    end

    // R7: a response only follows a load strobe of the previous cycle
    p_rvalid_src_r7: assert property (@(posedge clk) disable iff (rst)
        mmio_rvalid |-> $past(mmio_rd && !mmio_wr));

    // R2: a load to a foreign region never produces a response
    p_region_r2: assert property (@(posedge clk) disable iff (rst)
        (mmio_rd && mmio_addr[7:5] != POST_REGION) |=> !mmio_rvalid);

endmodule

// File: tb/dring_tracker_tb.sv
module dring_tracker_tb;
    import dring_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NR = 4;
    localparam int D  = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          mmio_wr = 1'b0, mmio_rd = 1'b0;
    logic [7:0]    mmio_addr = '0;
    logic [31:0]   mmio_wdata = '0;
    logic          mmio_rvalid;
    logic [32:0]   mmio_rdata;
    logic          fetch_valid = 1'b0, complete_valid = 1'b0, flush_wr = 1'b0, flush_val = 1'b0;
    logic [4:0]    fetch_ring = '0, complete_ring = '0, flush_ring = '0;
    logic [NR-1:0] ring_pending;

    int n_chk = 0;
    int n_bad = 0;
    int m_head [NR];
    int m_avail[NR];
    int m_comp [NR];
    bit m_gen  [NR];
    bit m_wake [NR];
    bit m_flush[NR];

    dring_tracker #(.NUM_RINGS(NR), .DEPTH(D)) u_dut (
        .clk(clk), .rst(rst),
        .mmio_wr(mmio_wr), .mmio_rd(mmio_rd), .mmio_addr(mmio_addr), .mmio_wdata(mmio_wdata),
        .mmio_rvalid(mmio_rvalid), .mmio_rdata(mmio_rdata),
        .fetch_valid(fetch_valid), .fetch_ring(fetch_ring),
        .complete_valid(complete_valid), .complete_ring(complete_ring),
        .flush_wr(flush_wr), .flush_ring(flush_ring), .flush_val(flush_val),
        .ring_pending(ring_pending)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic bit exp_pending(int r);
        return (m_avail[r] != 0) || m_wake[r];
    endfunction

    task automatic raw_wr(logic [7:0] a, logic [31:0] d);
        mmio_wr = 1'b1; mmio_addr = a; mmio_wdata = d;
        tick();
        mmio_wr = 1'b0;
    endtask

    task automatic post(int r, int idx, int cnt);
        int nt, gap;
        raw_wr({3'd5, 5'(r)}, {16'(cnt), 16'(idx)});
        if (cnt == 0) begin
            m_wake[r] = 1'b1;
        end else begin
            nt  = (idx + cnt) % D;
            gap = (nt - m_head[r] + D) % D;
            m_avail[r] = (gap == 0) ? D : gap;
        end
    endtask

    task automatic fetch(int r);
        fetch_valid = 1'b1; fetch_ring = 5'(r);
        tick();
        fetch_valid = 1'b0;
        if (exp_pending(r)) begin
            m_head[r] = (m_head[r] + 1) % D;
            if (m_head[r] == 0) m_gen[r] = ~m_gen[r];
            if (m_avail[r] > 0) m_avail[r]--;
            m_wake[r] = 1'b0;
        end
    endtask

    task automatic complete(int r);
        complete_valid = 1'b1; complete_ring = 5'(r);
        tick();
        complete_valid = 1'b0;
        m_comp[r] = (m_comp[r] + 1) % 65536;
    endtask

    task automatic flush(int r, bit v);
        flush_wr = 1'b1; flush_ring = 5'(r); flush_val = v;
        tick();
        flush_wr = 1'b0;
        if (m_flush[r] && !v) m_comp[r] = 0;
        m_flush[r] = v;
    endtask

    task automatic read_chk(int r, string tag);
        mmio_rd = 1'b1; mmio_addr = {3'd5, 5'(r)};
        tick();
        mmio_rd = 1'b0;
        check({tag, " rvalid"}, 64'(mmio_rvalid), 64'(1));
        check({tag, " data"}, 64'(mmio_rdata), 64'({m_gen[r], 16'(m_comp[r]), 16'(m_head[r])}));
        check({tag, " pending"}, 64'(ring_pending[r]), 64'(exp_pending(r)));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog for every requirement: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int n;
        int exp_n;
        for (int r = 0; r < NR; r++) begin
            m_head[r] = 0; m_avail[r] = 0; m_comp[r] = 0;
            m_gen[r] = 0; m_wake[r] = 0; m_flush[r] = 0;
        end
        repeat (3) tick();
        check("R1 rvalid in reset", 64'(mmio_rvalid), 64'(0));
        check("R1 pending in reset", 64'(ring_pending), 64'(0));
        rst = 1'b0;
        tick();
        for (int r = 0; r < NR; r++) read_chk(r, "R1 reset state");

        // R7: response lasts a single cycle
        tick();
        check("R7 rvalid drops", 64'(mmio_rvalid), 64'(0));

        // R3 R5 R6: index-by-count sweep on ring 1
        for (int idx = 0; idx < D; idx++) begin
            for (int cnt = 1; cnt <= D; cnt++) begin
                post(1, idx, cnt);
                exp_n = m_avail[1];
                check("R3 pending after post", 64'(ring_pending[1]), 64'(1));
                n = 0;
                while (ring_pending[1] && n < 2 * D) begin
                    fetch(1);
                    n++;
                end
                check("R3 R5 fetches to drain", 64'(n), 64'(exp_n));
                read_chk(1, "R6 head and generation");
            end
        end

        // R5: idle fetch has no effect
        fetch(3);
        read_chk(3, "R5 idle fetch");

        // R3 full post, R6 wrap on ring 3
        post(3, 0, D);
        check("R3 full outstanding", 64'(m_avail[3]), 64'(D));
        for (int k = 0; k < D; k++) fetch(3);
        check("R6 generation after wrap", 64'(m_gen[3]), 64'(1));
        read_chk(3, "R6 wrap read");

        // R4: wake-up with count 0
        post(2, 0, 0);
        check("R4 woken ring pending", 64'(ring_pending[2]), 64'(1));
        read_chk(2, "R4 wake leaves head");
        fetch(2);
        read_chk(2, "R4 wake fetch advances head");
        check("R4 wake cleared", 64'(ring_pending[2]), 64'(0));

        // R2: rejected accesses
        raw_wr({3'd4, 5'd0}, {16'd3, 16'd0});
        check("R2 wrong region write", 64'(ring_pending), 64'({2'b00, 1'b0, 1'b0}));
        raw_wr({3'd5, 5'd9}, {16'd3, 16'd0});
        check("R2 ring out of range", 64'(ring_pending), 64'(0));
        raw_wr({3'd5, 5'd0}, {16'd2, 16'(D)});
        check("R2 index out of range", 64'(ring_pending), 64'(0));
        mmio_rd = 1'b1; mmio_addr = {3'd6, 5'd0};
        tick();
        mmio_rd = 1'b0;
        check("R2 wrong region read", 64'(mmio_rvalid), 64'(0));
        read_chk(0, "R2 ring 0 untouched");

        // R8 and R9
        for (int k = 0; k < 5; k++) complete(0);
        read_chk(0, "R8 five completions");
        flush(0, 1'b1);
        read_chk(0, "R9 set keeps count");
        complete(0); complete(0);
        read_chk(0, "R8 count keeps rolling");
        flush(0, 1'b0);
        read_chk(0, "R9 clear resets count");
        complete(0);
        flush(0, 1'b1);
        flush_wr = 1'b1; flush_ring = 5'd0; flush_val = 1'b0;
        complete_valid = 1'b1; complete_ring = 5'd0;
        tick();
        flush_wr = 1'b0; complete_valid = 1'b0;
        m_comp[0] = 0; m_flush[0] = 1'b0;
        read_chk(0, "R9 clear beats completion");
        flush(0, 1'b0);
        read_chk(0, "R9 repeated zero write");

        // R10: every ring matches its own model
        post(2, 1, 3);
        for (int r = 0; r < NR; r++) read_chk(r, "R10 ring independence");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule